// File: doc/BRIEF.md
# Block Cipher Control and I/O Sequencer

This controller runs an iterative block-cipher datapath and the handshakes around it. It first takes a key from the input side through a request/acknowledge pair. The acknowledge pulse also starts an external key-expansion unit. The controller then counts expansion cycles for that unit until the unit reports that it has finished. Only after that does it accept data blocks.

For each block, the controller latches the encrypt/decrypt choice. It steps through one initial transformation, a parameterised number of rounds and one final transformation. During these steps it drives a round number that addresses the round-key memory. It then writes the result to an output side that can push back with a full flag.

The datapath, the key expansion and the key memory are outside this block. They are steered through the step flags, the round number and the cycle number.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `key_rd_o`, `data_rd_o`, `out_wr_o`, `step_init_o`, `step_round_o` and `step_final_o` are low and `round_o` is 0.
- R2: When `key_avail_i` is high and no block is in flight, `key_rd_o` pulses for exactly one cycle. This pulse also starts key expansion. From the next cycle, `ks_cycle_o` reads 0, 1, 2, … and advances by one each cycle until `keysched_done_i` is seen high.
- R3: `data_rd_o` never pulses between a `key_rd_o` pulse and the following `keysched_done_i`. It never pulses before the first key has been read. A key is never read while a block is in flight. If both `key_avail_i` and `data_avail_i` are high while the controller waits for data, the key is taken.
- R4: `data_rd_o` is high in the same cycle as `data_avail_i` while the controller waits for data, and it lasts one cycle. `enc_dec_i` (1 = encrypt, 0 = decrypt) is sampled in that cycle. `mode_o` shows the sampled value and does not change until the next `data_rd_o`.
- R5: The cycle after `data_rd_o`, `step_init_o` is high for one cycle. `step_round_o` is then high for exactly ROUNDS cycles, and after that `step_final_o` is high for one cycle. At most one step flag is high in any cycle.
- R6: When encrypting, `round_o` is 0 in the initial step, 1 up to ROUNDS during the rounds, and ROUNDS+1 in the final step. When decrypting, `round_o` is ROUNDS+1 in the initial step, ROUNDS down to 1 during the rounds, and 0 in the final step.
- R7: `out_wr_o` is never high while `out_full_i` is high. After the final step, `out_wr_o` pulses in the first cycle in which `out_full_i` is low. Every accepted block produces exactly one write.
- R8: After a write, the controller waits for data again. A new block or a new key can be accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_dec_i | input | 1 | 1 = encrypt, 0 = decrypt; sampled at data read |
| key_avail_i | input | 1 | Input side holds a key |
| key_rd_o | output | 1 | Key accepted; also starts key expansion |
| keysched_done_i | input | 1 | Key expansion has finished |
| ks_cycle_o | output | CYC_W | Cycle number for the key expansion unit |
| data_avail_i | input | 1 | Input side holds a data block |
| data_rd_o | output | 1 | Data block accepted |
| mode_o | output | 1 | Latched encrypt/decrypt mode |
| step_init_o | output | 1 | Datapath performs the initial transformation |
| step_round_o | output | 1 | Datapath performs one round |
| step_final_o | output | 1 | Datapath performs the final transformation |
| round_o | output | $clog2(ROUNDS+2) | Round-key memory address |
| out_full_i | input | 1 | Output side cannot take a write |
| out_wr_o | output | 1 | Write of the result |

## Verification
A state that is off by one shows up within one cycle as a round number that departs from the expected up or down sequence. It can also show as a step flag held for the wrong number of cycles. The scoreboard compares each such cycle against the mode recorded when the block was read. A controller stuck in the output state, or one that leaves it while the output side is full, is seen in the first cycle in which full drops without a write, or in which a write meets full. A lost key-expansion wait shows as a data read before the expansion unit reports done.

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl #(
  parameter int ROUNDS = 12,
  parameter int CYC_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enc_dec_i,
  input  logic                          key_avail_i,
  output logic                          key_rd_o,
  input  logic                          keysched_done_i,
  output logic [CYC_W-1:0]              ks_cycle_o,
  input  logic                          data_avail_i,
  output logic                          data_rd_o,
  output logic                          mode_o,
  output logic                          step_init_o,
  output logic                          step_round_o,
  output logic                          step_final_o,
  output logic [$clog2(ROUNDS+2)-1:0]   round_o,
  input  logic                          out_full_i,
  output logic                          out_wr_o
);
  localparam int RND_W = $clog2(ROUNDS+2);
  localparam logic [RND_W-1:0] R_LAST = RND_W'(ROUNDS);
  localparam logic [RND_W-1:0] R_FIN  = RND_W'(ROUNDS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD_KEY, S_WAIT_KS, S_WAIT_DATA, S_INIT, S_ROUND, S_FINAL, S_OUTPUT
  } state_t;

  state_t state, nxt;
  logic [RND_W-1:0] rnd;
  logic [CYC_W-1:0] cyc;
  logic             mode;

  wire key_take = (state == S_IDLE || state == S_WAIT_DATA) && key_avail_i;

  assign key_rd_o     = state == S_LOAD_KEY;
  assign data_rd_o    = state == S_WAIT_DATA && data_avail_i && !key_avail_i;
  assign step_init_o  = state == S_INIT;
  assign step_round_o = state == S_ROUND;
  assign step_final_o = state == S_FINAL;
  assign out_wr_o     = state == S_OUTPUT && !out_full_i;
  assign round_o      = rnd;
  assign ks_cycle_o   = cyc;
  assign mode_o       = mode;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:      if (key_take) nxt = S_LOAD_KEY;
      S_LOAD_KEY:  nxt = S_WAIT_KS;
      S_WAIT_KS:   if (keysched_done_i) nxt = S_WAIT_DATA;
      S_WAIT_DATA: if (key_take) nxt = S_LOAD_KEY;
                   else if (data_avail_i) nxt = S_INIT;
      S_INIT:      nxt = S_ROUND;
      S_ROUND:     if (rnd == (mode ? R_LAST : RND_W'(1))) nxt = S_FINAL;
      S_FINAL:     nxt = S_OUTPUT;
      S_OUTPUT:    if (!out_full_i) nxt = S_WAIT_DATA;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rnd   <= '0;
      cyc   <= '0;
      mode  <= 1'b0;
    end else begin
      state <= nxt;
      if (data_rd_o) begin
        mode <= enc_dec_i;
        rnd  <= enc_dec_i ? '0 : R_FIN;
      end else if (state == S_INIT || state == S_ROUND) begin
        rnd <= mode ? rnd + 1'b1 : rnd - 1'b1;
      end
      if (key_rd_o) cyc <= '0;
      else if (state == S_WAIT_KS && cyc != '1) cyc <= cyc + 1'b1;
    end
  end
endmodule

module cipher_seq_ctrl_chk #(
  parameter int ROUNDS = 12,
  parameter int RND_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_rd_o,
  input logic             data_rd_o,
  input logic             mode_o,
  input logic             step_init_o,
  input logic             step_round_o,
  input logic             step_final_o,
  input logic [RND_W-1:0] round_o,
  input logic             out_full_i,
  input logic             out_wr_o
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_o |-> !out_full_i); // R7
  AST_KEY_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd_o |=> !key_rd_o); // R2
  AST_DATA_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_o |=> !data_rd_o); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_o |=> $stable(mode_o)); // R4
  AST_READ_THEN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_o |=> step_init_o); // R5
  AST_INIT_THEN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_init_o |=> step_round_o); // R5
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_init_o, step_round_o, step_final_o, out_wr_o, data_rd_o, key_rd_o})); // R5
  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_round_o |-> (round_o >= RND_W'(1) && round_o <= RND_W'(ROUNDS))); // R6
  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_round_o && $past(step_round_o)) |->
      (round_o == $past(round_o) + (mode_o ? RND_W'(1) : '1))); // R6
endmodule

bind cipher_seq_ctrl cipher_seq_ctrl_chk #(.ROUNDS(ROUNDS), .RND_W($clog2(ROUNDS+2))) i_chk (
  .clk(clk), .rst_n(rst_n), .key_rd_o(key_rd_o), .data_rd_o(data_rd_o), .mode_o(mode_o),
  .step_init_o(step_init_o), .step_round_o(step_round_o), .step_final_o(step_final_o),
  .round_o(round_o), .out_full_i(out_full_i), .out_wr_o(out_wr_o));

// File: tb/test_cipher_seq_ctrl.sv
module test_cipher_seq_ctrl;
  localparam int ROUNDS = 12;
  localparam int CYC_W  = 8;
  localparam int RND_W  = $clog2(ROUNDS+2);

  logic clk = 0, rst_n = 0;
  logic enc_dec_i = 0, key_avail_i = 0, keysched_done_i = 0, data_avail_i = 0, out_full_i = 0;
  logic key_rd_o, data_rd_o, mode_o, step_init_o, step_round_o, step_final_o, out_wr_o;
  logic [CYC_W-1:0] ks_cycle_o;
  logic [RND_W-1:0] round_o;

  int tests = 0, fails = 0;
  logic exp_q[$];
  int pos = 0, ks_delay = 4, ks_cnt = 0, reads = 0, writes = 0, cycles = 0;
  bit ks_wait = 0, ks_ok = 0, in_out = 0, full_forced = 0, done = 0;

  always #4 clk = ~clk;

  cipher_seq_ctrl #(.ROUNDS(ROUNDS), .CYC_W(CYC_W)) i_cipher_seq_ctrl (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // key expansion model
  always @(negedge clk) begin
    if (!rst_n) begin
      ks_wait = 0; ks_ok = 0; keysched_done_i = 0;
    end else begin
      keysched_done_i = 0;
      if (ks_wait) begin
        check(ks_cycle_o == CYC_W'(ks_cnt), "R2 ks_cycle", ks_cycle_o, ks_cnt);
        if (ks_cnt == ks_delay) begin
          keysched_done_i = 1; ks_wait = 0; ks_ok = 1;
        end
        ks_cnt++;
      end
      if (key_rd_o) begin
        ks_wait = 1; ks_cnt = 0; ks_ok = 0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_rd_o) begin
        reads++;
        check(ks_ok && !ks_wait, "R3 read before key ready", 1, 0);
      end
      if (key_rd_o) check(exp_q.size() == 0, "R3 key read mid-block", exp_q.size(), 0);
      if (out_wr_o) check(!out_full_i, "R7 write while full", out_full_i, 0);
      if (step_init_o || step_round_o || step_final_o) begin
        automatic logic m = exp_q.size() > 0 ? exp_q[0] : 1'b0;
        automatic int er = m ? pos : ROUNDS + 1 - pos;
        check(exp_q.size() > 0, "R5 step without block", 0, 1);
        check(step_init_o == (pos == 0) && step_round_o == (pos >= 1 && pos <= ROUNDS)
              && step_final_o == (pos == ROUNDS + 1), "R5 step order", pos, pos);
        check(round_o == RND_W'(er), "R6 round number", round_o, er);
        check(mode_o == m, "R4 mode held", mode_o, m);
        pos++;
        if (step_final_o) in_out = 1;
      end else if (in_out) begin
        if (out_wr_o) begin
          writes++;
          check(exp_q.size() > 0 && pos == ROUNDS + 2, "R7 write count", pos, ROUNDS + 2);
          if (exp_q.size() > 0) begin
            check(mode_o == exp_q[0], "R4 mode at write", mode_o, exp_q[0]);
            void'(exp_q.pop_front());
          end
          pos = 0; in_out = 0;
        end else begin
          check(out_full_i, "R7 stall without full", out_full_i, 1);
        end
      end else begin
        check(!out_wr_o, "R7 stray write", out_wr_o, 0);
      end
    end
  end

  // random back-pressure
  always @(posedge clk) begin
    #1;
    if (!full_forced) out_full_i = ($urandom % 3) == 0;
  end

  task automatic send_key(input int dly);
    @(posedge clk); #1;
    ks_delay = dly;
    key_avail_i = 1;
    forever begin
      @(negedge clk);
      if (key_rd_o) break;
    end
    @(posedge clk); #1;
    key_avail_i = 0;
    while (!ks_ok) @(negedge clk);
  endtask

  task automatic send_block(input logic m);
    @(posedge clk); #1;
    enc_dec_i = m;
    data_avail_i = 1;
    forever begin
      @(negedge clk);
      if (data_rd_o) begin exp_q.push_back(m); break; end
    end
    @(posedge clk); #1;
    data_avail_i = 0;
    enc_dec_i = ~m;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!key_rd_o && !data_rd_o && !out_wr_o, "R1 strobes in reset", 1, 0);
    check(!step_init_o && !step_round_o && !step_final_o, "R1 steps in reset", 1, 0);
    check(round_o == 0, "R1 round in reset", round_o, 0);
    @(posedge clk); #1 rst_n = 1;
    data_avail_i = 1;
    @(negedge clk);
    check(!data_rd_o && !key_rd_o && !out_wr_o && round_o == 0, "R1 first cycle", data_rd_o, 0);
    repeat (5) @(negedge clk);
    // R3 no read without key
    check(reads == 0, "R3 no key no read", reads, 0);
    @(posedge clk); #1 data_avail_i = 0;

    send_key(6);
    for (int i = 0; i < 6; i++) begin send_block(1'b1); drain(); end
    for (int i = 0; i < 6; i++) begin send_block(1'b0); drain(); end

    // R7 long stall
    full_forced = 1; out_full_i = 1;
    send_block(1'b1);
    repeat (ROUNDS + 25) @(negedge clk);
    check(exp_q.size() == 1, "R7 held while full", exp_q.size(), 1);
    @(posedge clk); #1 out_full_i = 0;
    @(negedge clk);
    check(out_wr_o, "R7 write when full drops", out_wr_o, 1);
    full_forced = 0;
    drain();

    // R3 key request during a block waits; key wins over data
    fork
      send_block(1'b0);
      begin repeat (4) @(posedge clk); send_key(3); end
    join
    drain();
    key_avail_i = 1; data_avail_i = 1;
    @(negedge clk);
    check(!data_rd_o, "R3 key priority", data_rd_o, 0);
    key_avail_i = 0; data_avail_i = 0;
    ks_delay = 9;
    while (!ks_ok) @(negedge clk);

    // R8 back-to-back and random mix
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 6 == 0) send_key(1 + $urandom % 10);
      send_block(1'($urandom));
      if ($urandom % 2) drain();
      else begin
        while (!out_wr_o) @(negedge clk);
      end
      repeat ($urandom % 3) @(posedge clk);
    end
    drain();
    repeat (3) @(negedge clk);
    check(reads == writes, "R7 one write per block", writes, reads);
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) check(0, "watchdog", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule